// File: doc/BRIEF.md
# Programmable Clock Divider with Duty Control

This block derives a slower clock from a reference clock by an integer ratio, with a high time that is set separately. It suits a sample clock or a frame clock. Two register-style inputs control it. The divide setting `div_val_i` uses a zero-based code: a value `v` of 1 or more gives a period of `v+1` reference cycles. The value 0 gates the output, which then stays low. The high-time setting `high_cnt_i` holds the output high for `h+1` cycles of each period, so the duty is `(h+1)/(v+1)`. For example, `v=3` and `h=1` gives divide-by-4 at 50%.

A counter runs on the reference clock. It counts from 0 up to the active divide value and then wraps. Both settings go into shadow registers, and only when the counter wraps or when the block leaves the gated state. A change to either input therefore never shortens or stretches the period that is running. If the high-time setting is larger than the divide setting, it is clamped to the divide setting, and the output then stays high.

The controller has three states:
- `ST_GATED`: the output is low and the counter is held.
- `ST_HIGH`: the output is high.
- `ST_LOW`: the output is low.

It has these transitions:
- **start**: from `ST_GATED` to `ST_HIGH`, when a non-zero divide value is sampled.
- **fall**: from `ST_HIGH` to `ST_LOW`, when the count reaches the active high value before the end of the period.
- **wrap**: from `ST_HIGH` or `ST_LOW` to `ST_HIGH`, at the end of a period when the sampled divide value is non-zero.
- **stop**: from `ST_HIGH` or `ST_LOW` to `ST_GATED`, at the end of a period when the sampled divide value is zero.

Top module: `clkdiv_duty`

## Requirements
- R1: After a synchronous active-high reset, `clk_o` and `enabled_o` are both 0.
- R2: While gated (divide value 0), `clk_o` stays 0 and produces no edges, whatever `high_cnt_i` does.
- R3: For a divide value v of 1 or more, the period of `clk_o` is exactly v+1 reference cycles.
- R4: Each period begins with a rising edge of `clk_o`, and `clk_o` is high for h+1 reference cycles of the period when h <= v.
- R5: When h > v, h is clamped to v, so `clk_o` stays high for the whole period and holds high across periods.
- R6: A change of either input during a period does not alter that period; the new values apply from the next period.
- R7: On leaving the gated state, `clk_o` is high at the first edge after a non-zero divide value is sampled, and the first period is a full one.
- R8: `enabled_o` is 1 while the active divide value is non-zero. After the divide input is written to 0, `enabled_o` falls only at the end of the period in progress.
- R9: The all-ones divide value gives the largest ratio, 2^DIV_W reference cycles per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| div_val_i | input | DIV_W | Divide setting, zero-based; 0 gates |
| high_cnt_i | input | DIV_W | High-time setting, zero-based |
| clk_o | output | 1 | Divided clock, registered |
| enabled_o | output | 1 | High while a non-zero divide value is active |

## Verification
The assertions assume that the settings are static register values, driven only from the reference clock domain. They also assume that the shadowed high value never exceeds the shadowed divide value. The clamp guarantees this last point whatever the inputs are. The bench changes inputs only on the falling edge, away from the sampling edge. It uses both in-range and out-of-range high values, so the clamp path is exercised against the assertions as well as the other paths.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    typedef enum logic [1:0] {
        ST_GATED = 2'd0,
        ST_HIGH  = 2'd1,
        ST_LOW   = 2'd2
    } div_state_t;
endpackage

// File: rtl/clkdiv_shadow.sv
module clkdiv_shadow #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [DIV_W-1:0] div_in_i,
    input  logic [DIV_W-1:0] hi_in_i,
    output logic [DIV_W-1:0] sh_div_o,
    output logic [DIV_W-1:0] sh_hi_o
);
    logic [DIV_W-1:0] hi_clamped;

    always_comb begin
        if (hi_in_i > div_in_i) hi_clamped = div_in_i;
        else                    hi_clamped = hi_in_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sh_div_o <= '0;
            sh_hi_o  <= '0;
        end else if (load_i) begin
            sh_div_o <= div_in_i;
            sh_hi_o  <= hi_clamped;
        end
    end

    // R5
    hi_clamp_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        sh_hi_o <= sh_div_o);

    // R6
    shadow_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !load_i |=> ($stable(sh_div_o) && $stable(sh_hi_o)));
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clear_i,
    input  logic             run_i,
    output logic [DIV_W-1:0] cnt_o
);
    localparam logic [DIV_W-1:0] CNT_MAX = {DIV_W{1'b1}};

    always_ff @(posedge clk_i) begin
        if (rst_i)        cnt_o <= '0;
        else if (clear_i) cnt_o <= '0;
        else if (run_i)   cnt_o <= cnt_o + 1'b1;
    end

    // R9
    cnt_no_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_i && !clear_i) |-> (cnt_o != CNT_MAX));
endmodule

// File: rtl/clkdiv_fsm.sv
module clkdiv_fsm
    import clkdiv_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [DIV_W-1:0] div_in_i,
    input  logic [DIV_W-1:0] cnt_i,
    input  logic [DIV_W-1:0] sh_div_i,
    input  logic [DIV_W-1:0] sh_hi_i,
    output logic             load_o,
    output logic             run_o,
    output logic             clk_o,
    output logic             enabled_o
);
    div_state_t state_q, state_d;
    logic       at_end;
    logic       at_hi;
    logic       go;

    always_comb begin
        at_end = (state_q != ST_GATED) && (cnt_i == sh_div_i);
        at_hi  = (cnt_i == sh_hi_i);
        go     = (div_in_i != '0);
        load_o = (state_q == ST_GATED) || at_end;
        run_o  = (state_q != ST_GATED) && !at_end;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GATED: state_d = go ? ST_HIGH : ST_GATED;
            ST_HIGH: begin
                if (at_end)     state_d = go ? ST_HIGH : ST_GATED;
                else if (at_hi) state_d = ST_LOW;
            end
            ST_LOW: begin
                if (at_end) state_d = go ? ST_HIGH : ST_GATED;
            end
            default: state_d = ST_GATED;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_GATED;
        else       state_q <= state_d;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) clk_o <= 1'b0;
        else       clk_o <= (state_d == ST_HIGH);
    end

    assign enabled_o = (state_q != ST_GATED);

    // R7
    start_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ((state_q == ST_GATED) && go) |=> clk_o);

    // R2
    stay_gated_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ((state_q == ST_GATED) && !go) |=> (!clk_o && !enabled_o));
endmodule

// File: rtl/clkdiv_duty.sv
module clkdiv_duty #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [DIV_W-1:0] div_val_i,
    input  logic [DIV_W-1:0] high_cnt_i,
    output logic             clk_o,
    output logic             enabled_o
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] sh_div;
    logic [DIV_W-1:0] sh_hi;
    logic             load;
    logic             run;

    clkdiv_shadow #(.DIV_W(DIV_W)) u_shadow (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .load_i   (load),
        .div_in_i (div_val_i),
        .hi_in_i  (high_cnt_i),
        .sh_div_o (sh_div),
        .sh_hi_o  (sh_hi)
    );

    clkdiv_counter #(.DIV_W(DIV_W)) u_counter (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clear_i (load),
        .run_i   (run),
        .cnt_o   (cnt)
    );

    clkdiv_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .div_in_i  (div_val_i),
        .cnt_i     (cnt),
        .sh_div_i  (sh_div),
        .sh_hi_i   (sh_hi),
        .load_o    (load),
        .run_o     (run),
        .clk_o     (clk_o),
        .enabled_o (enabled_o)
    );

    // R2
    gated_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !enabled_o |-> !clk_o);

    // R4
    rise_at_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(clk_o) |-> (cnt == '0));

    // R3
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        enabled_o |-> (cnt <= sh_div));

    // R8
    enabled_nonzero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        enabled_o |-> (sh_div != '0));
endmodule

// File: tb/clkdiv_duty_tb.sv
module clkdiv_duty_tb_top;
    localparam int DIV_W = 8;
    localparam int NVEC  = 8;
    // columns: divide value, high value, expected period, expected high time
    localparam int VEC [NVEC][4] = '{
        '{1,   0,   2,   1},
        '{3,   1,   4,   2},
        '{4,   0,   5,   1},
        '{4,   2,   5,   3},
        '{7,   6,   8,   7},
        '{2,   2,   3,   3},
        '{5,   9,   6,   6},
        '{255, 127, 256, 128}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [DIV_W-1:0] div_val = '0;
    logic [DIV_W-1:0] high_cnt = '0;
    logic             clk_o;
    logic             enabled_o;
    int               checks = 0;
    int               failures = 0;
    bit               done = 1'b0;

    always #2.5 clk = ~clk;

    clkdiv_duty #(.DIV_W(DIV_W)) dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .div_val_i  (div_val),
        .high_cnt_i (high_cnt),
        .clk_o      (clk_o),
        .enabled_o  (enabled_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic go_gated();
        div_val = '0;
        for (int i = 0; i < 600 && enabled_o; i++) @(negedge clk);
        chk(!enabled_o && !clk_o, "R8 stop reached gated", enabled_o, 0);
    endtask

    task automatic meas(output int h, output int l);
        h = 1;
        l = 0;
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            if (clk_o) h++;
            else break;
        end
        if (!clk_o) begin
            l = 1;
            for (int i = 0; i < 700; i++) begin
                @(negedge clk);
                if (!clk_o) l++;
                else break;
            end
        end
    endtask

    initial begin
        int h, l;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(clk_o == 1'b0 && enabled_o == 1'b0, "R1 reset outputs", {clk_o, enabled_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(clk_o == 1'b0, "R2 idle after reset", clk_o, 0);

        for (int v = 0; v < NVEC; v++) begin
            go_gated();
            div_val  = VEC[v][0][DIV_W-1:0];
            high_cnt = VEC[v][1][DIV_W-1:0];
            @(negedge clk);
            // R7: first period starts at once
            chk(clk_o == 1'b1, "R7 first edge", clk_o, 1);
            chk(enabled_o == 1'b1, "R8 enabled while running", enabled_o, 1);
            if (VEC[v][3] == VEC[v][2]) begin
                // R5: clamped high value holds output high
                bit all_hi = 1'b1;
                for (int k = 0; k < 3 * VEC[v][2]; k++) begin
                    @(negedge clk);
                    if (!clk_o) all_hi = 1'b0;
                end
                chk(all_hi, "R5 held high", all_hi, 1);
            end else begin
                meas(h, l);
                // R4 high time, R3 period, R9 for the widest vector
                chk(h == VEC[v][3], "R4 high time", h, VEC[v][3]);
                chk(h + l == VEC[v][2], (v == NVEC-1) ? "R9 max period" : "R3 period", h + l, VEC[v][2]);
                meas(h, l);
                chk(h + l == VEC[v][2], "R3 steady period", h + l, VEC[v][2]);
            end
        end

        // R6: mid-run change applies from next period
        go_gated();
        div_val = 8'd3; high_cnt = 8'd1;
        @(negedge clk);
        div_val = 8'd5; high_cnt = 8'd2;
        meas(h, l);
        chk(h == 2 && l == 2, "R6 old period kept", h * 10 + l, 22);
        meas(h, l);
        chk(h == 3 && l == 3, "R6 new period", h * 10 + l, 33);

        // R8: gate request waits for period end
        div_val = '0;
        repeat (5) @(negedge clk);
        chk(enabled_o == 1'b1, "R8 still enabled in period", enabled_o, 1);
        @(negedge clk);
        chk(enabled_o == 1'b0, "R8 disabled at boundary", enabled_o, 0);

        // R2: gated output ignores high value changes
        begin
            bit quiet = 1'b1;
            for (int k = 0; k < 20; k++) begin
                high_cnt = k[DIV_W-1:0];
                @(negedge clk);
                if (clk_o || enabled_o) quiet = 1'b0;
            end
            chk(quiet, "R2 gated quiet", quiet, 1);
        end

        // R1: reset during run
        div_val = 8'd4; high_cnt = 8'd1;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(clk_o == 1'b0 && enabled_o == 1'b0, "R1 mid-run reset", {clk_o, enabled_o}, 0);
        rst = 1'b0;
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule